// File: doc/BRIEF.md
# General-Purpose I/O Bank with Event Detection

This block is one bank of 32 general-purpose lines on a simple single-cycle register bus. Software sets the value driven on each line and picks whether the line is an input or an output. It reads the pin state after a two-flop synchronizer. It also picks, line by line, which pin conditions raise an event: low level, high level, rising edge and falling edge. These four are independent and may be enabled together.

Events collect in a sticky status register that is cleared by writing ones. Two masks act on the status. The interrupt mask forms a single bank interrupt. The wakeup mask forms a wakeup request. Three registers have a pair of set and clear alias addresses, so that software can change some bits without a read-modify-write: data-out, interrupt mask and wakeup mask. A write on the bus takes effect at the clock edge where `bus_wr` is high. Read data is a combinational decode of `bus_addr` and has no side effects.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, direction reads 0xFFFFFFFF (all inputs). Data-out, interrupt mask, wakeup mask, all four detect registers and status read 0. `bank_irq` and `wake_req` are low.
- R2: Offset 0x00 reads the revision: minor number in bits 3:0, major number in bits 7:4, upper bits zero (0x21 by default). Offset 0x14 reads 1 in bit 0 (reset complete).
- R3: Data-out is at 0x3C and drives `pin_out`. A write to 0x94 sets only the 1-bits of the mask. A write to 0x90 clears only the 1-bits. Reads of 0x90 and 0x94 return data-out.
- R4: Direction is at 0x34. A 1 makes the line an input. `pin_is_input` mirrors the register.
- R5: Data-in at 0x38 shows `pin_in` as it was two clock edges earlier.
- R6: Rising-edge detect is at 0x48 and falling-edge detect at 0x4C. An edge of the synchronized pin sets the line's status bit one edge after it reaches data-in. The bit stays set until it is cleared.
- R7: Low-level detect is at 0x40 and high-level detect at 0x44. The status bit is set again on every edge while the level holds, so a clear has no lasting effect until the level goes away.
- R8: Status is at 0x18. Writing a 1 clears that bit and a 0 leaves it unchanged. A new event on the same bit in the same cycle wins over the clear.
- R9: The interrupt mask is at 0x1C, with clear alias 0x60 and set alias 0x64. `bank_irq` is high when any line has both status and mask set.
- R10: The wakeup mask has clear alias 0x80 and set alias 0x84, and both read it back. `wake_req` is high when any line has both status and wakeup mask set.
- R11: Offsets 0x10 (configuration) and 0x30 (control) are plain read/write storage. An unmapped offset reads 0, and a write to it changes nothing.
- R12: Several detect types enabled on one line combine: either edge, or level plus edge, each sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Raw line inputs |
| pin_out | output | 32 | Line output values |
| pin_is_input | output | 32 | Per-line direction, 1 = input |
| bank_irq | output | 1 | Combined bank interrupt |
| wake_req | output | 1 | Combined wakeup request |

## Verification
The bench checks several corner cases. One is a clear landing on a level-held line in the same cycle. A design that gives the clear priority would drop the bit for one cycle and lose the event. Another is an idle, sticky edge status. If that bit decayed or were re-armed by the level, the status would read wrong a few cycles after the edge. The bench writes the status with zero bits and writes the alias addresses with sparse masks; a plain-write implementation would corrupt the neighbouring bits. It times the synchronizer stages so that a missing or extra flop shows as a one-cycle shift. A random phase with every detect type mixed across lines compares status, interrupt and wakeup against the model on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_REV,
        SEL_CFG,
        SEL_SSTAT,
        SEL_ISTAT,
        SEL_IEN,
        SEL_CTRL,
        SEL_DIR,
        SEL_DIN,
        SEL_DOUT,
        SEL_LLO,
        SEL_LHI,
        SEL_RISE,
        SEL_FALL,
        SEL_IEN_CLR,
        SEL_IEN_SET,
        SEL_WK_CLR,
        SEL_WK_SET,
        SEL_DOUT_CLR,
        SEL_DOUT_SET
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [7:0] a);
        reg_sel_e s;
        unique case (a)
            8'h00:   s = SEL_REV;
            8'h10:   s = SEL_CFG;
            8'h14:   s = SEL_SSTAT;
            8'h18:   s = SEL_ISTAT;
            8'h1C:   s = SEL_IEN;
            8'h30:   s = SEL_CTRL;
            8'h34:   s = SEL_DIR;
            8'h38:   s = SEL_DIN;
            8'h3C:   s = SEL_DOUT;
            8'h40:   s = SEL_LLO;
            8'h44:   s = SEL_LHI;
            8'h48:   s = SEL_RISE;
            8'h4C:   s = SEL_FALL;
            8'h60:   s = SEL_IEN_CLR;
            8'h64:   s = SEL_IEN_SET;
            8'h80:   s = SEL_WK_CLR;
            8'h84:   s = SEL_WK_SET;
            8'h90:   s = SEL_DOUT_CLR;
            8'h94:   s = SEL_DOUT_SET;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            stage1 <= raw;
            cur    <= stage1;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] en_low,
    input  logic [W-1:0] en_high,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    output logic [W-1:0] event_hit
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic lvl_lo, lvl_hi, edg_up, edg_dn;
        assign lvl_lo = en_low[i]  & ~cur[i];
        assign lvl_hi = en_high[i] &  cur[i];
        assign edg_up = en_rise[i] &  cur[i] & ~prev[i];
        assign edg_dn = en_fall[i] & ~cur[i] &  prev[i];
        assign event_hit[i] = lvl_lo | lvl_hi | edg_up | edg_dn;
    end
endmodule

// File: rtl/gpio_bank_status.sv
module gpio_bank_status #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] event_hit,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | event_hit;
    end

    // A fresh event beats a same-cycle clear on the same bit
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_hit) |=> ((status & $past(event_hit)) == $past(event_hit)));

    // A set bit that was not cleared is still set one cycle later
    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr_mask)) |=>
        ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
    import gpio_bank_pkg::*;
#(
    parameter int unsigned LINES     = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned AW        = 8,
    parameter logic [3:0]  REV_MAJOR = 4'd2,
    parameter logic [3:0]  REV_MINOR = 4'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] pin_out,
    output logic [LINES-1:0] pin_is_input,
    output logic             bank_irq,
    output logic             wake_req
);
    localparam logic [DW-1:0] REV_WORD = DW'({REV_MAJOR, REV_MINOR});
    localparam logic [DW-1:0] DONE_WORD = DW'(1);

    reg_sel_e         sel;
    logic [LINES-1:0] wmask;
    logic [LINES-1:0] dout, dir_in, irq_en, wake_en;
    logic [LINES-1:0] en_low, en_high, en_rise, en_fall;
    logic [DW-1:0]    cfg_q, ctrl_q;
    logic [LINES-1:0] cur, prev, event_hit, clr_mask, status;

    assign sel   = decode_offset(8'(bus_addr));
    assign wmask = bus_wdata[LINES-1:0];

    gpio_bank_sync #(.W(LINES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prev(prev)
    );

    gpio_bank_detect #(.W(LINES)) detect_i (
        .cur(cur), .prev(prev),
        .en_low(en_low), .en_high(en_high), .en_rise(en_rise), .en_fall(en_fall),
        .event_hit(event_hit)
    );

    assign clr_mask = (bus_wr && sel == SEL_ISTAT) ? wmask : '0;

    gpio_bank_status #(.W(LINES)) status_i (
        .clk(clk), .rst_n(rst_n), .event_hit(event_hit),
        .clr_mask(clr_mask), .status(status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dir_in  <= '1;
            irq_en  <= '0;
            wake_en <= '0;
            en_low  <= '0;
            en_high <= '0;
            en_rise <= '0;
            en_fall <= '0;
            cfg_q   <= '0;
            ctrl_q  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_CFG:      cfg_q   <= bus_wdata;
                SEL_CTRL:     ctrl_q  <= bus_wdata;
                SEL_IEN:      irq_en  <= wmask;
                SEL_DIR:      dir_in  <= wmask;
                SEL_DOUT:     dout    <= wmask;
                SEL_LLO:      en_low  <= wmask;
                SEL_LHI:      en_high <= wmask;
                SEL_RISE:     en_rise <= wmask;
                SEL_FALL:     en_fall <= wmask;
                SEL_IEN_CLR:  irq_en  <= irq_en & ~wmask;
                SEL_IEN_SET:  irq_en  <= irq_en | wmask;
                SEL_WK_CLR:   wake_en <= wake_en & ~wmask;
                SEL_WK_SET:   wake_en <= wake_en | wmask;
                SEL_DOUT_CLR: dout    <= dout & ~wmask;
                SEL_DOUT_SET: dout    <= dout | wmask;
                default:      ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_REV:                   bus_rdata = REV_WORD;
            SEL_CFG:                   bus_rdata = cfg_q;
            SEL_SSTAT:                 bus_rdata = DONE_WORD;
            SEL_ISTAT:                 bus_rdata = DW'(status);
            SEL_IEN, SEL_IEN_CLR,
            SEL_IEN_SET:               bus_rdata = DW'(irq_en);
            SEL_CTRL:                  bus_rdata = ctrl_q;
            SEL_DIR:                   bus_rdata = DW'(dir_in);
            SEL_DIN:                   bus_rdata = DW'(cur);
            SEL_DOUT, SEL_DOUT_CLR,
            SEL_DOUT_SET:              bus_rdata = DW'(dout);
            SEL_LLO:                   bus_rdata = DW'(en_low);
            SEL_LHI:                   bus_rdata = DW'(en_high);
            SEL_RISE:                  bus_rdata = DW'(en_rise);
            SEL_FALL:                  bus_rdata = DW'(en_fall);
            SEL_WK_CLR, SEL_WK_SET:    bus_rdata = DW'(wake_en);
            default:                   bus_rdata = '0;
        endcase
    end

    assign pin_out      = dout;
    assign pin_is_input = dir_in;
    assign bank_irq     = |(status & irq_en);
    assign wake_req     = |(status & wake_en);

    assert_set_dout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_DOUT_SET) |=>
        ((pin_out & $past(wmask)) == $past(wmask)));

    assert_clr_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_IEN_CLR) |=> ((irq_en & $past(wmask)) == '0));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> ((|irq_en) && (|status)));

    assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((|wake_en) && (|status)));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_is_input;
    logic        bank_irq, wake_req;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_is_input(pin_is_input),
        .bank_irq(bank_irq), .wake_req(wake_req)
    );

    // Behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev, m_stat, m_ie, m_wk, m_out, m_dir;
    logic [31:0] m_llo, m_lhi, m_rise, m_fall, m_cfg, m_ctrl;

    always @(posedge clk or negedge rst_n) begin : model
        logic [31:0] ev, clr;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_ie = 0; m_wk = 0;
            m_out = 0; m_dir = '1; m_llo = 0; m_lhi = 0; m_rise = 0; m_fall = 0;
            m_cfg = 0; m_ctrl = 0;
        end else begin
            ev = 0;
            for (int i = 0; i < 32; i++) begin
                if (m_llo[i] && !m_s2[i]) ev[i] = 1'b1;
                if (m_lhi[i] && m_s2[i]) ev[i] = 1'b1;
                if (m_rise[i] && m_s2[i] && !m_prev[i]) ev[i] = 1'b1;
                if (m_fall[i] && !m_s2[i] && m_prev[i]) ev[i] = 1'b1;
            end
            clr = (bus_wr && bus_addr == 8'h18) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~clr) | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (bus_wr) begin
                case (bus_addr)
                    8'h10: m_cfg = bus_wdata;
                    8'h30: m_ctrl = bus_wdata;
                    8'h1C: m_ie = bus_wdata;
                    8'h34: m_dir = bus_wdata;
                    8'h3C: m_out = bus_wdata;
                    8'h40: m_llo = bus_wdata;
                    8'h44: m_lhi = bus_wdata;
                    8'h48: m_rise = bus_wdata;
                    8'h4C: m_fall = bus_wdata;
                    8'h60: m_ie = m_ie & ~bus_wdata;
                    8'h64: m_ie = m_ie | bus_wdata;
                    8'h80: m_wk = m_wk & ~bus_wdata;
                    8'h84: m_wk = m_wk | bus_wdata;
                    8'h90: m_out = m_out & ~bus_wdata;
                    8'h94: m_out = m_out | bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'h21;
            8'h10: return m_cfg;
            8'h14: return 32'h1;
            8'h18: return m_stat;
            8'h1C, 8'h60, 8'h64: return m_ie;
            8'h30: return m_ctrl;
            8'h34: return m_dir;
            8'h38: return m_s2;
            8'h3C, 8'h90, 8'h94: return m_out;
            8'h40: return m_llo;
            8'h44: return m_lhi;
            8'h48: return m_rise;
            8'h4C: return m_fall;
            8'h80, 8'h84: return m_wk;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every cycle: outputs against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            chk("R3 pin_out", pin_out, m_out);
            chk("R4 pin_is_input", pin_is_input, m_dir);
            chk("R9 bank_irq", 32'(bank_irq), 32'(|(m_stat & m_ie)));
            chk("R10 wake_req", 32'(wake_req), 32'(|(m_stat & m_wk)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, model_read(a));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic [31:0] lfsr;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1'b1;

        // R1 reset state
        rd("R1 dir", 8'h34, 32'hFFFF_FFFF);
        rd("R1 dout", 8'h3C, 32'h0);
        rd("R1 ien", 8'h1C, 32'h0);
        rd("R1 wake", 8'h84, 32'h0);
        rd("R1 status", 8'h18, 32'h0);
        rd("R1 llo", 8'h40, 32'h0);
        rd("R1 lhi", 8'h44, 32'h0);
        rd("R1 rise", 8'h48, 32'h0);
        rd("R1 fall", 8'h4C, 32'h0);
        chk("R1 irq", 32'(bank_irq), 32'h0);
        chk("R1 wake_req", 32'(wake_req), 32'h0);
        // R2 revision and reset-complete
        rd("R2 rev", 8'h00, 32'h21);
        rd("R2 sysstatus", 8'h14, 32'h1);

        // R3 data-out and its aliases
        wr(8'h3C, 32'hA5A5_0000);
        rd("R3 dout", 8'h3C, 32'hA5A5_0000);
        wr(8'h94, 32'h0000_00FF);
        rd("R3 set alias", 8'h90, 32'hA5A5_00FF);
        wr(8'h90, 32'hA000_000F);
        rd("R3 clr alias", 8'h94, 32'h05A5_00F0);
        chk("R3 pin_out", pin_out, 32'h05A5_00F0);

        // R4 direction
        wr(8'h34, 32'h0000_FFFF);
        rd("R4 dir", 8'h34, 32'h0000_FFFF);
        chk("R4 pins", pin_is_input, 32'h0000_FFFF);

        // R5 two-stage synchronizer
        pin_in = 32'h1234_5678;
        tick(1);
        rd("R5 datain one edge", 8'h38, 32'h0);
        tick(1);
        rd("R5 datain two edges", 8'h38, 32'h1234_5678);
        pin_in = 32'h0;
        tick(4);

        // R6 rising edge, sticky
        wr(8'h48, 32'h8);
        wr(8'h64, 32'h8);
        rd("R9 ien set alias", 8'h1C, 32'h8);
        pin_in = 32'h8;
        tick(1);
        rd("R6 status early", 8'h18, 32'h0);
        tick(1);
        rd("R6 status early2", 8'h18, 32'h0);
        tick(1);
        rd("R6 rise status", 8'h18, 32'h8);
        chk("R9 irq on", 32'(bank_irq), 32'h1);
        tick(5);
        rd("R6 sticky", 8'h18, 32'h8);
        // R8 zero bits leave status alone, ones clear
        wr(8'h18, 32'h0);
        rd("R8 zero write", 8'h18, 32'h8);
        wr(8'h18, 32'h8);
        rd("R8 w1c", 8'h18, 32'h0);
        chk("R9 irq off", 32'(bank_irq), 32'h0);

        // R12 both edges on one line
        wr(8'h4C, 32'h8);
        pin_in = 32'h0;
        tick(3);
        rd("R12 fall with rise", 8'h18, 32'h8);
        wr(8'h18, 32'h8);
        pin_in = 32'h8;
        tick(3);
        rd("R12 rise with fall", 8'h18, 32'h8);
        wr(8'h18, 32'hFFFF_FFFF);
        rd("R6 cleared", 8'h18, 32'h0);

        // R7 level high with R8 event-wins
        pin_in = 32'h28;
        wr(8'h44, 32'h20);
        tick(3);
        rd("R7 level high", 8'h18, 32'h20);
        wr(8'h18, 32'h20);
        rd("R8 event beats clear", 8'h18, 32'h20);
        pin_in = 32'h08;
        tick(3);
        wr(8'h18, 32'h20);
        rd("R7 level gone", 8'h18, 32'h0);

        // R7 level low, R10 wakeup
        wr(8'h40, 32'h80);
        tick(2);
        rd("R7 level low", 8'h18, 32'h80);
        wr(8'h84, 32'h80);
        rd("R10 wake set", 8'h80, 32'h80);
        chk("R10 wake_req on", 32'(wake_req), 32'h1);
        wr(8'h80, 32'h80);
        rd("R10 wake clr", 8'h84, 32'h0);
        chk("R10 wake_req off", 32'(wake_req), 32'h0);
        wr(8'h40, 32'h0);
        wr(8'h18, 32'h80);
        rd("R7 low released", 8'h18, 32'h0);
        wr(8'h60, 32'h8);
        rd("R9 ien clr alias", 8'h64, 32'h0);

        // R11 storage and unmapped
        wr(8'h10, 32'h0000_0015);
        rd("R11 cfg", 8'h10, 32'h0000_0015);
        wr(8'h30, 32'h0000_0001);
        rd("R11 ctrl", 8'h30, 32'h0000_0001);
        wr(8'h7C, 32'hDEAD_BEEF);
        rd("R11 unmapped", 8'h7C, 32'h0);
        rd("R11 dout untouched", 8'h3C, 32'h05A5_00F0);

        // Mixed random phase against the model
        wr(8'h40, 32'h0000_000F);
        wr(8'h44, 32'h0000_00F0);
        wr(8'h48, 32'h0F0F_0F00);
        wr(8'h4C, 32'h00FF_0F00);
        wr(8'h1C, 32'h5555_AAAA);
        wr(8'h84, 32'h0000_FF0F);
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pin_in = lfsr;
            if (k % 7 == 3) wr(8'h18, {lfsr[15:0], lfsr[31:16]});
            else if (k % 11 == 5) wr(8'h94, lfsr & 32'h0000_0F0F);
            else tick(1);
            rd("R8 random status", 8'h18, model_read(8'h18));
            rd("R5 random datain", 8'h38, model_read(8'h38));
        end
        tick(2);
        finish_run();
    end
endmodule